// File: doc/BRIEF.md
# Bidirectional Pin Interface Cell Group

This block sits between a group of bidirectional pins and a programmable logic array. For each pin it provides an output side and an input side. On the output side it picks one of four values offered by the pin's logic cell: three combinational sum terms (A, B, C) or the cell's register output Q. It can invert the picked value, then drives it toward the pad together with an enable taken from the cell's fourth sum term (D).

On the input side a capture element feeds the array. The element can work as an edge-triggered register, as a transparent latch, or be skipped. When a pin is configured as a dedicated output, its pad is always driven. The capture element then takes sum term D instead of the pad value, which gives the array one more buried storage bit.

All pins of the group share one capture clock supplied by a global clock cell. Each pin has its own static configuration. The pad is modelled as three plain signals (value out, enable out, value in), so the pad's electrical behaviour stays outside the block.

Top module: `pin_io_group`

## Requirements
- R1: The output value is chosen per pin by a 2-bit select: code 0 picks sum A, code 1 sum B, code 2 sum C, code 3 the logic cell register Q.
- R2: With the pin's invert bit at 1, `pad_out` is the complement of the chosen value; with it at 0 it is the chosen value unchanged.
- R3: With the dedicated-output bit at 0, `pad_oe` follows sum D combinationally.
- R4: Capture mode code 1 (register): the feedback changes only on a rising edge of `cap_clk`, taking the source value present at that edge, and holds between edges.
- R5: Capture mode code 2 (latch): while `cap_clk` is high the feedback follows the source value.
- R6: In latch mode, while `cap_clk` is low the feedback keeps the value it had when the clock fell, whatever the source does.
- R7: Capture mode code 0 or 3 (bypass): the feedback equals the source value with no clock involved.
- R8: With the dedicated-output bit at 1, `pad_oe` is held at 1. The capture source is sum D instead of `pad_in`, so `pad_in` has no effect on the feedback.
- R9: While `rst_n` is low, both capture elements of every pin read 0. After `rst_n` rises, the register first captures on the third rising edge of `cap_clk`; the reset release takes effect on the second edge.
- R10: Each pin uses only its own configuration and its own sum terms; pins set to different selections give their own results at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_clk | input | 1 | Capture clock from the global clock cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| sum_a | input | NPIN | Sum term A for each pin |
| sum_b | input | NPIN | Sum term B for each pin |
| sum_c | input | NPIN | Sum term C for each pin |
| sum_d | input | NPIN | Sum term D for each pin (enable or buried data) |
| lcc_q | input | NPIN | Logic cell register output for each pin |
| cfg_osel | input | 2*NPIN | Output select code, 2 bits per pin |
| cfg_inv | input | NPIN | Output invert bit for each pin |
| cfg_cap | input | 2*NPIN | Capture mode code, 2 bits per pin |
| cfg_ded | input | NPIN | Dedicated-output bit for each pin |
| pad_in | input | NPIN | Value seen at each pad |
| pad_out | output | NPIN | Value driven toward each pad |
| pad_oe | output | NPIN | Driver enable for each pad |
| fb | output | NPIN | Capture path value returned to the array |

## Verification
The hardest case to reach is telling a latch that holds apart from one that is transparent, and telling a register from a latch. All three show the same value at a clock edge. The difference only appears when the source changes inside a single clock phase. The stimulus therefore changes `pad_in` or sum D in the middle of a high phase and again in the middle of a low phase, and samples the feedback before that phase ends. The buried-register case is reached by driving `pad_in` and sum D to opposite values, so that a capture of the wrong source gives a visible difference.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    OSEL_A = 2'd0,
    OSEL_B = 2'd1,
    OSEL_C = 2'd2,
    OSEL_Q = 2'd3
  } osel_e;

  typedef enum logic [1:0] {
    CAP_THRU  = 2'd0,
    CAP_FLOP  = 2'd1,
    CAP_LATCH = 2'd2,
    CAP_THRU2 = 2'd3
  } capm_e;

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_nxt;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path
  import pio_pkg::*;
(
  input  osel_e sel,
  input  logic  inv,
  input  logic  ded,
  input  logic  sa,
  input  logic  sb,
  input  logic  sc,
  input  logic  sd,
  input  logic  q,
  output logic  drv,
  output logic  oe
);
  logic picked;

  always_comb begin
    unique case (sel)
      OSEL_A:  picked = sa;
      OSEL_B:  picked = sb;
      OSEL_C:  picked = sc;
      default: picked = q;
    endcase
  end

  assign drv = picked ^ inv;
  assign oe  = ded | sd;
endmodule

// File: rtl/pio_capture.sv
module pio_capture
  import pio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  capm_e mode,
  input  logic  ded,
  input  logic  pin_val,
  input  logic  sd,
  output logic  fb
);
  logic d_src;
  logic flop_q, flop_nxt, flop_en;
  logic lat_q, lat_en;

  assign d_src   = ded ? sd : pin_val;
  assign flop_en = (mode == CAP_FLOP);
  assign lat_en  = clk & (mode == CAP_LATCH);

  always_comb begin
    flop_nxt = flop_en ? d_src : flop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flop_q <= 1'b0;
    else        flop_q <= flop_nxt;
  end

  always_latch begin
    if (!rst_n)      lat_q <= 1'b0;
    else if (lat_en) lat_q <= d_src;
  end

  always_comb begin
    unique case (mode)
      CAP_FLOP:  fb = flop_q;
      CAP_LATCH: fb = lat_q;
      default:   fb = d_src;
    endcase
  end

  // Checker state for the assertions below
  logic seen_q;
  logic fell_q;
  logic hold_ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fell_q     <= 1'b0;
      hold_ref_q <= 1'b0;
    end else begin
      fell_q     <= 1'b1;
      hold_ref_q <= lat_q;
    end
  end

  assert_flop_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(mode) == CAP_FLOP) |-> flop_q == $past(d_src));

  assert_latch_open_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == CAP_LATCH) |-> lat_q == d_src);

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fell_q |-> lat_q == hold_ref_q);

  assert_reset_zero_R9: assert property (@(posedge clk)
    !rst_n |-> (flop_q == 1'b0 && lat_q == 1'b0));
endmodule

// File: rtl/pin_io_group.sv
module pin_io_group
  import pio_pkg::*;
#(
  parameter int NPIN      = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              cap_clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   sum_a,
  input  logic [NPIN-1:0]   sum_b,
  input  logic [NPIN-1:0]   sum_c,
  input  logic [NPIN-1:0]   sum_d,
  input  logic [NPIN-1:0]   lcc_q,
  input  logic [2*NPIN-1:0] cfg_osel,
  input  logic [NPIN-1:0]   cfg_inv,
  input  logic [2*NPIN-1:0] cfg_cap,
  input  logic [NPIN-1:0]   cfg_ded,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   fb
);
  localparam int CODE_W = 2;

  logic cap_rst_n;

  pio_rst_sync #(.STAGES(SYNC_DEPTH)) u_rsync (
    .clk    (cap_clk),
    .arst_n (rst_n),
    .srst_n (cap_rst_n)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    osel_e sel_i;
    capm_e mode_i;

    assign sel_i  = osel_e'(cfg_osel[CODE_W*i +: CODE_W]);
    assign mode_i = capm_e'(cfg_cap[CODE_W*i +: CODE_W]);

    pio_out_path u_out (
      .sel (sel_i),
      .inv (cfg_inv[i]),
      .ded (cfg_ded[i]),
      .sa  (sum_a[i]),
      .sb  (sum_b[i]),
      .sc  (sum_c[i]),
      .sd  (sum_d[i]),
      .q   (lcc_q[i]),
      .drv (pad_out[i]),
      .oe  (pad_oe[i])
    );

    pio_capture u_cap (
      .clk     (cap_clk),
      .rst_n   (cap_rst_n),
      .mode    (mode_i),
      .ded     (cfg_ded[i]),
      .pin_val (pad_in[i]),
      .sd      (sum_d[i]),
      .fb      (fb[i])
    );

    assert_bypass_pin_R7: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      ((mode_i == CAP_THRU || mode_i == CAP_THRU2) && !cfg_ded[i]) |-> fb[i] == pad_in[i]);

    assert_bypass_buried_R8: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      ((mode_i == CAP_THRU || mode_i == CAP_THRU2) && cfg_ded[i]) |-> fb[i] == sum_d[i]);
  end
endmodule

// File: tb/pin_io_group_tb.sv
module pin_io_group_tb_top;
  localparam int NPIN = 4;

  logic              cap_clk = 1'b0;
  logic              rst_n;
  logic [NPIN-1:0]   sum_a, sum_b, sum_c, sum_d, lcc_q;
  logic [2*NPIN-1:0] cfg_osel, cfg_cap;
  logic [NPIN-1:0]   cfg_inv, cfg_ded, pad_in;
  logic [NPIN-1:0]   pad_out, pad_oe, fb;

  always #10 cap_clk = ~cap_clk;

  pin_io_group #(.NPIN(NPIN)) dut_i (
    .cap_clk (cap_clk), .rst_n (rst_n),
    .sum_a (sum_a), .sum_b (sum_b), .sum_c (sum_c), .sum_d (sum_d), .lcc_q (lcc_q),
    .cfg_osel (cfg_osel), .cfg_inv (cfg_inv), .cfg_cap (cfg_cap), .cfg_ded (cfg_ded),
    .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe), .fb (fb)
  );

  typedef struct {
    int    kind;   // 0 fb, 1 pad_out, 2 pad_oe
    int    pin;
    logic  val;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  event smp_ev;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic expect_v(input int kind, input int pin, input logic val, input string tag);
    exp_t e;
    #1;
    e.kind = kind; e.pin = pin; e.val = val; e.tag = tag;
    sb_q.push_back(e);
    ->smp_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(smp_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        logic act;
        e = sb_q.pop_front();
        case (e.kind)
          0:       act = fb[e.pin];
          1:       act = pad_out[e.pin];
          default: act = pad_oe[e.pin];
        endcase
        n_vec++;
        if (act !== e.val) begin
          n_bad++;
          $display("FAIL %s pin %0d signal %0d actual %b expected %b",
                   e.tag, e.pin, e.kind, act, e.val);
        end
      end
    end
  end

  task automatic hi();
    @(posedge cap_clk); #4;
  endtask

  task automatic lo();
    @(negedge cap_clk); #4;
  endtask

  task automatic set_cap(input int pin, input logic [1:0] code);
    cfg_cap[2*pin +: 2] = code;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all requirements actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sum_a = '0; sum_b = '0; sum_c = '0; sum_d = '0; lcc_q = '0;
    cfg_osel = '0; cfg_inv = '0; cfg_ded = '0;
    cfg_cap = {NPIN{2'd1}};
    pad_in = '1;

    // R9: reset state and synchronous release
    lo();
    for (int p = 0; p < NPIN; p++) expect_v(0, p, 1'b0, "R9 reset value");
    rst_n = 1'b1;
    hi(); expect_v(0, 0, 1'b0, "R9 first edge still reset");
    hi(); expect_v(0, 0, 1'b0, "R9 second edge release only");
    hi(); expect_v(0, 0, 1'b1, "R9 third edge first capture");
    expect_v(0, 1, 1'b1, "R9 third edge first capture");

    // R4: register mode
    lo(); pad_in[0] = 1'b0; expect_v(0, 0, 1'b1, "R4 hold while low");
    hi(); expect_v(0, 0, 1'b0, "R4 capture on rising edge");
    pad_in[0] = 1'b1; expect_v(0, 0, 1'b0, "R4 no capture inside high phase");
    hi(); expect_v(0, 0, 1'b1, "R4 next edge capture");

    // R5 / R6: latch mode on pin 1
    lo(); set_cap(1, 2'd2); pad_in[1] = 1'b1;
    expect_v(0, 1, 1'b0, "R6 latch closed while low");
    hi(); expect_v(0, 1, 1'b1, "R5 latch opens when high");
    pad_in[1] = 1'b0; expect_v(0, 1, 1'b0, "R5 transparent inside high phase");
    lo(); pad_in[1] = 1'b1; expect_v(0, 1, 1'b0, "R6 hold after fall");
    pad_in[1] = 1'b0; pad_in[1] = 1'b1; expect_v(0, 1, 1'b0, "R6 still holding");
    hi(); expect_v(0, 1, 1'b1, "R5 reopens");

    // R7: bypass on pin 2
    lo(); set_cap(2, 2'd0); pad_in[2] = 1'b0; expect_v(0, 2, 1'b0, "R7 bypass code 0");
    pad_in[2] = 1'b1; expect_v(0, 2, 1'b1, "R7 bypass code 0");
    hi(); set_cap(2, 2'd3); pad_in[2] = 1'b0; expect_v(0, 2, 1'b0, "R7 bypass code 3");

    // R8: dedicated output, buried register on pin 3
    lo(); cfg_ded[3] = 1'b1; sum_d[3] = 1'b0; pad_in[3] = 1'b1;
    expect_v(2, 3, 1'b1, "R8 enable forced");
    hi(); expect_v(0, 3, 1'b0, "R8 captures sum D not pad");
    lo(); sum_d[3] = 1'b1; pad_in[3] = 1'b0; expect_v(0, 3, 1'b0, "R8 hold between edges");
    hi(); expect_v(0, 3, 1'b1, "R8 captures sum D");
    lo(); set_cap(3, 2'd0); sum_d[3] = 1'b0; pad_in[3] = 1'b1;
    expect_v(0, 3, 1'b0, "R8 bypass follows sum D");
    expect_v(2, 3, 1'b1, "R8 enable stays forced");

    // R3: enable from sum D
    lo(); sum_d[0] = 1'b1; expect_v(2, 0, 1'b1, "R3 enable high");
    sum_d[0] = 1'b0; expect_v(2, 0, 1'b0, "R3 enable low");

    // R1 / R2: output select and polarity on pin 0
    for (int inv = 0; inv < 2; inv++) begin
      for (int code = 0; code < 4; code++) begin
        lo();
        cfg_osel[1:0] = 2'(code); cfg_inv[0] = 1'(inv);
        sum_a[0] = (code == 0); sum_b[0] = (code == 1);
        sum_c[0] = (code == 2); lcc_q[0] = (code == 3);
        expect_v(1, 0, 1'b1 ^ 1'(inv), "R1 R2 chosen source high");
        sum_a[0] = (code != 0); sum_b[0] = (code != 1);
        sum_c[0] = (code != 2); lcc_q[0] = (code != 3);
        expect_v(1, 0, 1'b0 ^ 1'(inv), "R1 R2 chosen source low");
      end
    end

    // R10: pins independent
    lo(); cfg_inv = '0; cfg_osel[1:0] = 2'd0; cfg_osel[3:2] = 2'd1;
    sum_a = '1; sum_b = '0;
    expect_v(1, 0, 1'b1, "R10 pin 0 picks A");
    expect_v(1, 1, 1'b0, "R10 pin 1 picks B");

    lo();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule